// File: doc/BRIEF.md
# SD Host Command and Response Register Front End

This block is the software-facing register front end of an SD/MMC host. A byte-wide register bus loads the fields of the next card command: a command index, a 32-bit argument, a response type, a control byte, a block length and a block count. Writing the control byte with its go bit set sends a one-cycle launch pulse to the command sequencer, which is outside this block. All programmed fields are presented on dedicated outputs.

Response bytes returned by the sequencer arrive on a byte-wide input and are stored in a 16-byte buffer that software reads back at offsets 0x10 to 0x1F. The buffer is rotated by one position: the last byte of a response sits at 0x10 and the first fifteen at 0x11 onward. Software then assembles four 32-bit words in a fixed order. A control bit rewinds the buffer's fill position before the next response. A separate request input loads an automatic stop-transmission command and launches it without a bus write.

Top module: `sdh_cmd_regs`

## Requirements
- R1: After a synchronous reset every register reads zero, `cmd_go` is low, `cmd_kind` is 0 and `blk_bytes` is 1.
- R2: A write to offset 0x00 stores bits 7:4 as the command kind and bit 2 as the write-direction flag. If bit 0 is set, `cmd_go` is high for exactly the one cycle after the write. Bits 0 and 3 read back as written during that cycle and read 0 afterwards. Bit 1 always reads 0.
- R3: The clearing of bits 0 and 3 leaves the kind and direction fields unchanged. Those fields change only on a write to offset 0x00 or on a stop request.
- R4: Offset 0x01 holds the command index and offset 0x02 the response type, both 8 bits. Offsets 0x04 to 0x07 hold the argument in little-endian order (0x04 carries `cmd_arg[7:0]`). All of these read back as written.
- R5: Offsets 0x0C (low byte) and 0x0D (high byte) form the 16-bit block-length register. Bits 10:0 hold the block size minus one, so `blk_bytes` ranges from 1 to 2048. `blk_flags[i]` equals register bit 11+i.
- R6: Offsets 0x0E (low byte) and 0x0F (high byte) form the 16-bit block count driven on `blk_count`.
- R7: The n-th response byte accepted on `rsp_vld` since the last rewind (n = 0..15) reads back at offset 0x10 + ((n+1) mod 16). Word k, byte j (least significant first) of the response is therefore at 0x10+4k+j+1, except word 3 byte 3, which is at 0x10.
- R8: Once 16 bytes have been accepted, further response bytes are ignored until the next rewind.
- R9: Writing 1 to control bit 3 rewinds the fill position without erasing the stored bytes, so the next accepted byte is stored as byte 0.
- R10: A one-cycle `stop_req` loads `stop_cmd` as the command index, kind 7 and response type 9, and raises `cmd_go` in the following cycle. The argument is left unchanged.
- R11: Offsets 0x03, 0x08 to 0x0B and 0x20 to 0x3F read zero and ignore writes. Bus writes to the response buffer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| rsp_vld | input | 1 | Response byte valid |
| rsp_byte | input | 8 | Response byte from the sequencer |
| stop_req | input | 1 | Request for an automatic stop command |
| stop_cmd | input | 8 | Command index used by the stop request |
| cmd_go | output | 1 | One-cycle launch pulse to the sequencer |
| cmd_kind | output | 4 | Command kind field |
| cmd_dir_wr | output | 1 | Data transfer direction is a write |
| cmd_index | output | 8 | Command index |
| cmd_rtype | output | 8 | Response type |
| cmd_arg | output | 32 | Command argument |
| blk_bytes | output | 12 | Block size in bytes (1 to 2048) |
| blk_flags | output | 5 | Block-length flag bits 15:11 |
| blk_count | output | 16 | Block count |

## Verification
The bench uses the default build: a 6-bit offset space and a 16-byte response buffer. At that size every offset of the map can be written with an arithmetic pattern and read back, so each hole and each read-only byte is checked one at a time. A full response fits in 16 clocks, so every slot of the rotation is compared with the arithmetically expected one. The wrap slot is included, as are fill-past-full and a partial refill after a rewind. The 11-bit size field is swept across its range, including 2048.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
    localparam int ADDR_W      = 6;
    localparam int RSP_BYTES   = 16;                 // power of two
    localparam int SLOT_W      = $clog2(RSP_BYTES);
    localparam int PTR_W       = SLOT_W + 1;
    localparam int BLK_SIZE_W  = 11;
    localparam int BLK_BYTES_W = BLK_SIZE_W + 1;
    localparam int FLAG_W      = 16 - BLK_SIZE_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 6'h01;
    localparam logic [ADDR_W-1:0] OFS_RTYPE = 6'h02;
    localparam logic [ADDR_W-1:0] OFS_ARG   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BLEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_BCNT  = 6'h0E;
    localparam logic [ADDR_W-1:0] OFS_RSP   = 6'h10;

    localparam logic [3:0] STOP_KIND  = 4'd7;
    localparam logic [7:0] STOP_RTYPE = 8'd9;

    typedef struct packed {
        logic [3:0] kind;
        logic       fifo_clr;
        logic       dir_wr;
        logic       rsvd;
        logic       go;
    } ctrl_t;

    // Buffer slot holding logical response byte n (rotated by one)
    function automatic logic [SLOT_W-1:0] rsp_slot(input logic [SLOT_W-1:0] n);
        return n + SLOT_W'(1);
    endfunction
endpackage

// File: rtl/sdh_ctrl_regs.sv
module sdh_ctrl_regs
    import sdh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              stop_req,
    input  logic [7:0]        stop_cmd,
    output ctrl_t             ctrl,
    output logic [7:0]        cmd_idx,
    output logic [7:0]        rtype,
    output logic [31:0]       arg,
    output logic [15:0]       blen,
    output logic [15:0]       bcnt
);
    logic ctrl_hit;
    assign ctrl_hit = wr_en && (waddr == OFS_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            cmd_idx <= '0;
            rtype   <= '0;
            arg     <= '0;
            blen    <= '0;
            bcnt    <= '0;
        end else begin
            ctrl.go       <= 1'b0;
            ctrl.fifo_clr <= 1'b0;
            if (ctrl_hit) begin
                ctrl.kind     <= wdata[7:4];
                ctrl.fifo_clr <= wdata[3];
                ctrl.dir_wr   <= wdata[2];
                ctrl.go       <= wdata[0];
            end
            if (wr_en && waddr == OFS_CMD)   cmd_idx <= wdata;
            if (wr_en && waddr == OFS_RTYPE) rtype   <= wdata;
            for (int b = 0; b < 4; b++) begin
                if (wr_en && waddr == OFS_ARG + ADDR_W'(b)) arg[8*b +: 8] <= wdata;
            end
            for (int b = 0; b < 2; b++) begin
                if (wr_en && waddr == OFS_BLEN + ADDR_W'(b)) blen[8*b +: 8] <= wdata;
                if (wr_en && waddr == OFS_BCNT + ADDR_W'(b)) bcnt[8*b +: 8] <= wdata;
            end
            if (stop_req) begin
                cmd_idx   <= stop_cmd;
                ctrl.kind <= STOP_KIND;
                rtype     <= STOP_RTYPE;
                ctrl.go   <= 1'b1;
            end
        end
    end

    assert_go_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_hit && wdata[0]) && !stop_req |=> !ctrl.go);

    assert_kind_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_hit && !stop_req |=> $stable(ctrl.kind) && $stable(ctrl.dir_wr));

    assert_stop_load_R10: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> ctrl.go && ctrl.kind == STOP_KIND && rtype == STOP_RTYPE);
endmodule

// File: rtl/sdh_rsp_buf.sv
module sdh_rsp_buf
    import sdh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rewind,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [7:0]        rd_byte
);
    logic [7:0]       slot_mem [RSP_BYTES];
    logic [PTR_W-1:0] fill_ptr;
    logic             full;

    assign full    = (fill_ptr == PTR_W'(RSP_BYTES));
    assign rd_byte = slot_mem[rd_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_ptr <= '0;
            for (int i = 0; i < RSP_BYTES; i++) slot_mem[i] <= '0;
        end else if (rewind) begin
            fill_ptr <= '0;
        end else if (byte_vld && !full) begin
            slot_mem[rsp_slot(fill_ptr[SLOT_W-1:0])] <= byte_in;
            fill_ptr <= fill_ptr + PTR_W'(1);
        end
    end

    assert_rewind_ptr_R9: assert property (@(posedge clk) disable iff (rst)
        rewind |=> fill_ptr == '0);

    assert_ptr_bound_R8: assert property (@(posedge clk) disable iff (rst)
        fill_ptr <= PTR_W'(RSP_BYTES));

    assert_full_hold_R8: assert property (@(posedge clk) disable iff (rst)
        full && !rewind |=> $stable(fill_ptr));
endmodule

// File: rtl/sdh_cmd_regs.sv
module sdh_cmd_regs
    import sdh_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic                   rsp_vld,
    input  logic [7:0]             rsp_byte,
    input  logic                   stop_req,
    input  logic [7:0]             stop_cmd,
    output logic                   cmd_go,
    output logic [3:0]             cmd_kind,
    output logic                   cmd_dir_wr,
    output logic [7:0]             cmd_index,
    output logic [7:0]             cmd_rtype,
    output logic [31:0]            cmd_arg,
    output logic [BLK_BYTES_W-1:0] blk_bytes,
    output logic [FLAG_W-1:0]      blk_flags,
    output logic [15:0]            blk_count
);
    ctrl_t       ctrl;
    logic [15:0] blen;
    logic [7:0]  rsp_rd;
    logic        rewind;

    assign rewind = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[3];

    sdh_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .waddr    (reg_addr),
        .wdata    (reg_wdata),
        .stop_req (stop_req),
        .stop_cmd (stop_cmd),
        .ctrl     (ctrl),
        .cmd_idx  (cmd_index),
        .rtype    (cmd_rtype),
        .arg      (cmd_arg),
        .blen     (blen),
        .bcnt     (blk_count)
    );

    sdh_rsp_buf u_rsp (
        .clk      (clk),
        .rst      (rst),
        .rewind   (rewind),
        .byte_vld (rsp_vld),
        .byte_in  (rsp_byte),
        .rd_slot  (reg_addr[SLOT_W-1:0]),
        .rd_byte  (rsp_rd)
    );

    assign cmd_go     = ctrl.go;
    assign cmd_kind   = ctrl.kind;
    assign cmd_dir_wr = ctrl.dir_wr;
    assign blk_bytes  = {1'b0, blen[BLK_SIZE_W-1:0]} + BLK_BYTES_W'(1);
    assign blk_flags  = blen[15:BLK_SIZE_W];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL)                     reg_rdata = ctrl;
        else if (reg_addr == OFS_CMD)                 reg_rdata = cmd_index;
        else if (reg_addr == OFS_RTYPE)               reg_rdata = cmd_rtype;
        else if (reg_addr[ADDR_W-1:2] == OFS_ARG[ADDR_W-1:2])
            reg_rdata = cmd_arg[{reg_addr[1:0], 3'b000} +: 8];
        else if (reg_addr[ADDR_W-1:1] == OFS_BLEN[ADDR_W-1:1])
            reg_rdata = blen[{reg_addr[0], 3'b000} +: 8];
        else if (reg_addr[ADDR_W-1:1] == OFS_BCNT[ADDR_W-1:1])
            reg_rdata = blk_count[{reg_addr[0], 3'b000} +: 8];
        else if (reg_addr[ADDR_W-1:SLOT_W] == OFS_RSP[ADDR_W-1:SLOT_W])
            reg_rdata = rsp_rd;
    end

    assert_hole_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 6'h03 || reg_addr[5:2] == 4'h2 || reg_addr[5]) |-> reg_rdata == 8'h00);

    assert_bit1_zero_R2: assert property (@(posedge clk) disable iff (rst)
        reg_addr == OFS_CTRL |-> reg_rdata[1] == 1'b0);
endmodule

// File: tb/sdh_cmd_regs_tb.sv
module sdh_cmd_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        rsp_vld = 1'b0;
    logic [7:0]  rsp_byte = '0;
    logic        stop_req = 1'b0;
    logic [7:0]  stop_cmd = '0;
    logic        cmd_go;
    logic [3:0]  cmd_kind;
    logic        cmd_dir_wr;
    logic [7:0]  cmd_index;
    logic [7:0]  cmd_rtype;
    logic [31:0] cmd_arg;
    logic [11:0] blk_bytes;
    logic [4:0]  blk_flags;
    logic [15:0] blk_count;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    logic [7:0] rsp_a [16];
    logic [7:0] exp_buf [16];

    always #4 clk = ~clk;

    sdh_cmd_regs dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic feed(input logic [7:0] b);
        rsp_vld = 1'b1; rsp_byte = b;
        @(posedge clk);
        @(negedge clk);
        rsp_vld = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // physical offset o holds logical byte (o+15)%16
    task automatic check_buf(input string req);
        logic [7:0] v;
        for (int o = 0; o < 16; o++) begin
            rd(6'(16 + o), v);
            check(req, v, exp_buf[(o + 15) % 16]);
        end
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 go", cmd_go, 0);
        check("R1 kind", cmd_kind, 0);
        check("R1 blk_bytes", blk_bytes, 1);
        for (int a = 0; a < 64; a++) begin
            rd(6'(a), v);
            check("R1 readback", v, 0);
        end

        // R4 R5 R6 R11: write pattern to every offset, read all back
        for (int a = 0; a < 64; a++) wr(6'(a), pat(a));
        @(negedge clk);
        for (int a = 0; a < 64; a++) begin
            logic [7:0] e;
            rd(6'(a), v);
            if (a == 0) e = pat(0) & 8'hF4;
            else if (a == 1 || a == 2 || (a >= 4 && a <= 7) || (a >= 12 && a <= 15)) e = pat(a);
            else e = 8'h00;   // R11 holes and read-only buffer
            check((a == 0) ? "R2 ctrl" : (a < 12) ? "R4/R11 map" : (a < 16) ? "R5/R6 map" : "R11 map", v, e);
        end
        check("R4 cmd_arg", cmd_arg, {pat(7), pat(6), pat(5), pat(4)});
        check("R4 cmd_index", cmd_index, pat(1));
        check("R4 cmd_rtype", cmd_rtype, pat(2));
        check("R6 blk_count", blk_count, {pat(15), pat(14)});
        check("R5 flags", blk_flags, pat(13) >> 3);

        // R5 block size sweep
        for (int s = 1; s <= 2048; s += 67) begin
            logic [15:0] reg16;
            reg16 = 16'(((s % 32) << 11) | (s - 1));
            wr(6'h0C, reg16[7:0]);
            wr(6'h0D, reg16[15:8]);
            check("R5 blk_bytes", blk_bytes, s);
            check("R5 blk_flags", blk_flags, s % 32);
        end
        wr(6'h0C, 8'hFF);
        wr(6'h0D, 8'hAF);
        check("R5 blk_bytes max", blk_bytes, 2048);
        check("R5 blk_flags max", blk_flags, 5'h15);

        // R2 R3 control byte
        wr(6'h00, 8'h75);
        check("R2 go pulse", cmd_go, 1);
        rd(6'h00, v); check("R2 ctrl during pulse", v, 8'h75);
        @(negedge clk);
        check("R2 go low", cmd_go, 0);
        rd(6'h00, v); check("R3 ctrl after clear", v, 8'h74);
        check("R3 kind kept", cmd_kind, 7);
        check("R3 dir kept", cmd_dir_wr, 1);
        wr(6'h01, 8'h11);
        wr(6'h06, 8'h22);
        check("R3 kind stable", cmd_kind, 7);
        wr(6'h00, 8'hA9);
        rd(6'h00, v); check("R2 fifo bit shown", v, 8'hA9);
        @(negedge clk);
        rd(6'h00, v); check("R3 after A9", v, 8'hA0);
        check("R3 dir cleared", cmd_dir_wr, 0);

        // R7 response capture and rotation
        wr(6'h00, 8'h08);
        for (int n = 0; n < 16; n++) begin
            rsp_a[n] = 8'(8'hC0 ^ (n * 29));
            exp_buf[n] = rsp_a[n];
            feed(rsp_a[n]);
        end
        check_buf("R7 slot");
        for (int k = 0; k < 4; k++) begin
            logic [31:0] w;
            for (int j = 0; j < 4; j++) begin
                int o;
                o = (k == 3 && j == 3) ? 16 : 16 + 4 * k + j + 1;
                rd(6'(o), v);
                w[8*j +: 8] = v;
            end
            check("R7 word", w, {rsp_a[4*k+3], rsp_a[4*k+2], rsp_a[4*k+1], rsp_a[4*k]});
        end

        // R8 overflow bytes ignored
        for (int n = 0; n < 4; n++) feed(8'hEE);
        check_buf("R8 full");

        // R11 bus writes to buffer ignored
        wr(6'h10, 8'h5A);
        wr(6'h1F, 8'h5A);
        check_buf("R11 rsp read-only");

        // R9 rewind keeps data, refills from byte 0
        wr(6'h00, 8'h08);
        for (int n = 0; n < 3; n++) begin
            exp_buf[n] = 8'(8'h3C + n * 7);
            feed(exp_buf[n]);
        end
        check_buf("R9 refill");

        // R10 stop request
        stop_cmd = 8'd12; stop_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stop_req = 1'b0;
        check("R10 go", cmd_go, 1);
        check("R10 kind", cmd_kind, 7);
        check("R10 rtype", cmd_rtype, 9);
        check("R10 index", cmd_index, 12);
        check("R10 arg kept", cmd_arg, {pat(7), 8'h22, pat(5), pat(4)});
        @(negedge clk);
        check("R10 go single", cmd_go, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule